// File: doc/BRIEF.md
# Channel Report Word Queue

This block holds a first-in first-out queue of pending channel report words. Event producers post a report. A report names a reporting-source code, an error-recovery code, a chain indication and a 16-bit resource identifier. The block packs these fields into a 32-bit word and appends it to the queue. A consumer pulses a store request. One cycle later it receives the oldest word and a condition code, or an all-zero word with condition code 1 when nothing is pending.

The block also drives a single-cycle machine-check request toward the processor. An armed flag gates this request. The first accepted post after arming raises the request and clears the flag. Only a store request that finds the queue empty sets the flag again, so the consumer is interrupted once per drain. If a post arrives when no slot is free, the report is dropped and a sticky loss indicator is set. The next report that is accepted carries a recovery flag, which tells the consumer that some reports were lost.

Top module: `crwq_top`

## Requirements
- R1: A stored word is laid out as follows. Bits 31:16 hold the flags field and bits 15:0 hold the resource identifier. In the flags field, the reporting-source code occupies flags bits 11:8 (word bits 27:24) and the error-recovery code occupies flags bits 5:0 (word bits 21:16).
- R2: When the chain input is high on a post, word bit 29 (flags bit 13) is set. Otherwise it is clear.
- R3: A store request is answered in the following cycle: `store_ack_o` is high for one cycle. When the queue holds data, the response returns the oldest word with condition code 0, and words leave in posting order.
- R4: A store request on an empty queue returns an all-zero word with condition code 1.
- R5: An accepted post made while armed produces a one-cycle `mchk_o` pulse in the next cycle and disarms the block. Accepted posts made while disarmed produce no pulse.
- R6: Only a store request that finds the queue empty re-arms the block; a store that returns a word does not. If a post is accepted in the same cycle as such an empty store, it raises the pulse.
- R7: A post made while the queue holds DEPTH words, without a store request in the same cycle, is dropped and marks reports as lost. The queue never exceeds DEPTH entries.
- R8: After a loss, the next accepted word has word bit 30 (flags bit 14) set, and the loss mark is cleared at that moment. Later words have bit 30 clear.
- R9: A post and a store request in the same cycle are both served, including when the queue is full. The store returns the oldest word and the posted word is appended.
- R10: Synchronous reset empties the queue, sets the armed flag and clears the loss mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| post_i | input | 1 | Post a report this cycle |
| post_src_i | input | SRC_W (4) | Reporting-source code |
| post_erc_i | input | ERC_W (6) | Error-recovery code |
| post_chain_i | input | 1 | Chain indication |
| post_rsid_i | input | 16 | Resource identifier |
| store_i | input | 1 | Store request (pop oldest word) |
| store_ack_o | output | 1 | Store response valid, one cycle after request |
| store_word_o | output | 32 | Returned report word |
| store_cc_o | output | 1 | Condition code: 0 delivered, 1 queue empty |
| mchk_o | output | 1 | Single-cycle machine-check request |

## Verification
The assertions assume the following about the inputs. `post_i` and `store_i` carry known values in every cycle after reset. Each high cycle counts as exactly one request, and the post fields are only sampled while `post_i` is high. The bench drives every input on the falling clock edge and returns the strobes to zero after each sampled rising edge. It holds reset for several cycles before the first request, so no request ever overlaps an unknown or partly reset state. Same-cycle post and store requests are generated deliberately, because the arming and slot-freeing rules depend on that overlap.

// File: rtl/crwq_pkg.sv
`timescale 1ns/1ps
package crwq_pkg;

    localparam int WORD_W   = 32;
    localparam int FLAG_W   = 16;
    localparam int RSID_W   = 16;
    localparam int SRC_LSB  = 8;
    localparam int RECOV_BIT = 14;
    localparam int CHAIN_BIT = 13;

    typedef logic [WORD_W-1:0] crw_word_t;
    typedef logic [FLAG_W-1:0] crw_flags_t;

    typedef struct packed {
        logic      armed;
        logic      lost;
        logic      mchk;
        logic      ack;
        logic      cc;
        crw_word_t word;
    } ctl_state_t;

endpackage

// File: rtl/crwq_fmt.sv
`timescale 1ns/1ps
module crwq_fmt
    import crwq_pkg::*;
#(
    parameter int SRC_W = 4,
    parameter int ERC_W = 6
) (
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ERC_W-1:0]  erc_i,
    input  logic              chain_i,
    input  logic              recov_i,
    input  logic [RSID_W-1:0] rsid_i,
    output crw_word_t         word_o
);

    crw_flags_t flags;

    always_comb begin
        flags                     = '0;
        flags[SRC_LSB +: SRC_W]   = src_i;
        flags[ERC_W-1:0]          = erc_i;
        flags[CHAIN_BIT]          = chain_i;
        flags[RECOV_BIT]          = recov_i;
        word_o                    = {flags, rsid_i};
    end

endmodule

// File: rtl/crwq_fifo.sv
`timescale 1ns/1ps
module crwq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wr = wrap_inc(st_q.wr);
        if (pop_i)  st_d.rd = wrap_inc(st_q.rd);
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[st_q.wr] <= din_i;
    end

    assign head_o  = mem_q[st_q.rd];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign count_o = st_q.cnt;

endmodule

// File: rtl/crwq_top.sv
`timescale 1ns/1ps
module crwq_top
    import crwq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SRC_W = 4,
    parameter int ERC_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              post_i,
    input  logic [SRC_W-1:0]  post_src_i,
    input  logic [ERC_W-1:0]  post_erc_i,
    input  logic              post_chain_i,
    input  logic [RSID_W-1:0] post_rsid_i,
    input  logic              store_i,
    output logic              store_ack_o,
    output logic [WORD_W-1:0] store_word_o,
    output logic              store_cc_o,
    output logic              mchk_o
);

    ctl_state_t ctl_d, ctl_q;

    crw_word_t        new_word;
    crw_word_t        fifo_head;
    logic             fifo_empty;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_cnt;
    logic             pop_ok;
    logic             push_ok;
    logic             empty_read;
    logic             armed_eff;

    crwq_fmt #(
        .SRC_W (SRC_W),
        .ERC_W (ERC_W)
    ) u_fmt (
        .src_i   (post_src_i),
        .erc_i   (post_erc_i),
        .chain_i (post_chain_i),
        .recov_i (ctl_q.lost),
        .rsid_i  (post_rsid_i),
        .word_o  (new_word)
    );

    crwq_fifo #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (push_ok),
        .din_i   (new_word),
        .pop_i   (pop_ok),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full),
        .count_o (fifo_cnt)
    );

    // A store that frees a slot lets a same-cycle post in even when full.
    assign pop_ok     = store_i & ~fifo_empty;
    assign empty_read = store_i &  fifo_empty;
    assign push_ok    = post_i & (~fifo_full | pop_ok);
    assign armed_eff  = ctl_q.armed | empty_read;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.mchk  = push_ok & armed_eff;
        ctl_d.armed = (push_ok & armed_eff) ? 1'b0 : armed_eff;
        if (push_ok)
            ctl_d.lost = 1'b0;
        else if (post_i)
            ctl_d.lost = 1'b1;
        ctl_d.ack   = store_i;
        ctl_d.cc    = empty_read;
        ctl_d.word  = pop_ok ? fifo_head : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q       <= '0;
            ctl_q.armed <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign store_ack_o  = ctl_q.ack;
    assign store_word_o = ctl_q.word;
    assign store_cc_o   = ctl_q.cc;
    assign mchk_o       = ctl_q.mchk;

endmodule

// File: rtl/crwq_chk.sv
`timescale 1ns/1ps
module crwq_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             post_i,
    input logic             store_i,
    input logic             store_ack_o,
    input logic [31:0]      store_word_o,
    input logic             store_cc_o,
    input logic             mchk_o,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_cnt
);

    p_ack_follows_store_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        store_i |=> store_ack_o);

    p_no_spurious_ack_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !store_i |=> !store_ack_o);

    p_empty_word_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (store_ack_o && store_cc_o) |-> (store_word_o == 32'h0));

    p_mchk_needs_post_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        mchk_o |-> $past(post_i));

    p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(fifo_cnt) <= DEPTH);

    p_full_empty_excl_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(fifo_full && fifo_empty));

    p_reset_empties_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> fifo_empty);

endmodule

bind crwq_top crwq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .post_i       (post_i),
    .store_i      (store_i),
    .store_ack_o  (store_ack_o),
    .store_word_o (store_word_o),
    .store_cc_o   (store_cc_o),
    .mchk_o       (mchk_o),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .fifo_cnt     (fifo_cnt)
);

// File: tb/crwq_top_bench.sv
`timescale 1ns/1ps
module crwq_top_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post = 1'b0;
    logic [3:0]  src = '0;
    logic [5:0]  erc = '0;
    logic        chain = 1'b0;
    logic [15:0] rsid = '0;
    logic        store = 1'b0;
    logic        ack;
    logic [31:0] word;
    logic        cc;
    logic        mchk;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    crwq_top #(.DEPTH(DEPTH)) u_crwq_top (
        .clk_i        (clk),
        .rst_i        (rst),
        .post_i       (post),
        .post_src_i   (src),
        .post_erc_i   (erc),
        .post_chain_i (chain),
        .post_rsid_i  (rsid),
        .store_i      (store),
        .store_ack_o  (ack),
        .store_word_o (word),
        .store_cc_o   (cc),
        .mchk_o       (mchk)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    // One clock with the given strobes; outputs sampled after the edge.
    task automatic step(input logic p, input logic [3:0] s, input logic [5:0] e,
                        input logic c, input logic [15:0] r, input logic st);
        @(negedge clk);
        post = p; src = s; erc = e; chain = c; rsid = r; store = st;
        @(posedge clk);
        #1;
        post = 1'b0; store = 1'b0;
    endtask

    task automatic put(input logic [15:0] r);
        step(1'b1, 4'h1, 6'h01, 1'b0, r, 1'b0);
    endtask

    task automatic get();
        step(1'b0, 4'h0, 6'h00, 1'b0, 16'h0, 1'b1);
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 2; i++) begin
            get();
            if (cc) break;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "mchk idle after reset", {31'b0, mchk}, 32'h0);
        check("R10", "ack idle after reset", {31'b0, ack}, 32'h0);
        get();
        check("R4", "empty store cc", {31'b0, cc}, 32'h1);
        check("R4", "empty store word", word, 32'h0);
        check("R3", "ack after store", {31'b0, ack}, 32'h1);
    endtask

    task automatic t_format();
        step(1'b1, 4'h5, 6'h2A, 1'b0, 16'h1234, 1'b0);
        check("R5", "pulse on armed post", {31'b0, mchk}, 32'h1);
        step(1'b1, 4'hC, 6'h03, 1'b1, 16'hBEEF, 1'b0);
        check("R5", "no pulse when disarmed", {31'b0, mchk}, 32'h0);
        get();
        check("R1", "word layout", word, 32'h052A_1234);
        check("R3", "cc delivered", {31'b0, cc}, 32'h0);
        get();
        check("R2", "chain bit 29", word, 32'h2C03_BEEF);
        step(1'b0, 4'h0, 6'h0, 1'b0, 16'h0, 1'b0);
        check("R3", "ack drops without store", {31'b0, ack}, 32'h0);
        get();
        check("R4", "empty after two", {31'b0, cc}, 32'h1);
        put(16'h0042);
        check("R6", "pulse after empty store", {31'b0, mchk}, 32'h1);
        drain();
    endtask

    task automatic t_arming();
        put(16'h00A0);
        check("R5", "armed post pulses", {31'b0, mchk}, 32'h1);
        get();
        check("R3", "nonempty store", word, 32'h0101_00A0);
        put(16'h00A1);
        check("R6", "nonempty store does not re-arm", {31'b0, mchk}, 32'h0);
        get();
        check("R3", "second word", word, 32'h0101_00A1);
        step(1'b1, 4'h1, 6'h01, 1'b0, 16'h00A2, 1'b1);
        check("R6", "empty store cc with post", {31'b0, cc}, 32'h1);
        check("R6", "same-cycle empty store re-arms", {31'b0, mchk}, 32'h1);
        get();
        check("R9", "post kept beside empty store", word, 32'h0101_00A2);
        drain();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) begin
            put(16'(i));
            check("R5", "pulse only on first fill", {31'b0, mchk}, (i == 0) ? 32'h1 : 32'h0);
        end
        put(16'hDEAD);
        put(16'hFEED);
        get();
        check("R3", "oldest after overflow", word, 32'h0101_0000);
        put(16'h0777);
        for (int i = 1; i < DEPTH; i++) begin
            get();
            check("R7", "kept word order", word, 32'h0101_0000 | 32'(i));
        end
        get();
        check("R8", "recovery flag on next accepted", word, 32'h4101_0777);
        get();
        check("R7", "dropped words absent", {31'b0, cc}, 32'h1);
        put(16'h0888);
        get();
        check("R8", "recovery flag only once", word, 32'h0101_0888);
        drain();
    endtask

    task automatic t_simul();
        for (int i = 0; i < DEPTH; i++) put(16'h0100 + 16'(i));
        step(1'b1, 4'h1, 6'h01, 1'b0, 16'h0ABC, 1'b1);
        check("R9", "store served while full", word, 32'h0101_0100);
        check("R9", "cc with same-cycle post", {31'b0, cc}, 32'h0);
        for (int i = 1; i < DEPTH; i++) begin
            get();
            check("R9", "order kept", word, 32'h0101_0100 | 32'(i));
        end
        get();
        check("R9", "full-slot post accepted, no loss", word, 32'h0101_0ABC);
        get();
        check("R9", "queue drained", {31'b0, cc}, 32'h1);
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < DEPTH + 1; i++) put(16'h0300 + 16'(i));
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        put(16'h0555);
        check("R10", "armed after reset", {31'b0, mchk}, 32'h1);
        get();
        check("R10", "queue emptied and loss cleared", word, 32'h0101_0555);
        get();
        check("R10", "empty after reset word", {31'b0, cc}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_format();
        t_arming();
        t_overflow();
        t_simul();
        t_reset_mid();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule